// File: doc/BRIEF.md
# Tagged Fully Associative Translation Buffer

This block caches recent page translations for a processor. Every stored entry holds a virtual page number, the process tag of its owner, a physical page number, a page-valid flag, separate kernel and user access rights, and reference, modify and cacheable flags. A lookup compares the requested page and the current process tag against all entries at once. One cycle later it reports one of four outcomes: a hit with the physical page, a miss, a page fault, or a protection fault.

A refill port installs a translation that a page walker has fetched. A mapping that is already present is rewritten in place. Otherwise the lowest-numbered empty slot is used, and when every slot is full a tree pseudo-LRU picks the victim. Software keeps the buffer coherent with the page tables in two ways. It drops one mapping with an invalidate command. It issues a context switch, which either just loads a new current process tag (tagged mode) or empties the whole buffer (untagged mode).

Top module: `tagged_tlb`

## Requirements
- R1: After reset every slot is empty, `res_valid_o` is 0, and any lookup reports a miss.
- R2: A lookup requested at one clock edge sets `res_valid_o` high with its result in the following cycle. The result codes are 0 hit, 1 miss, 2 page fault and 3 protection fault. A hit returns the physical page and the cacheable flag. Every non-hit result drives the page, cacheable, reference and modify outputs to 0.
- R3: An entry matches when it is occupied and its page equals the request. In tagged mode (`tag_en_i`=1) its tag must also equal the current process tag. A page stored under another tag reports a miss.
- R4: A matching entry whose page-valid flag is 0 reports a page fault. This takes priority over the rights check. It has no effect on the reference bit, the modify bit or the replacement state.
- R5: Rights fields encode 0 as none, 1 as read-only, and 2 or 3 as read-write. The user field applies when `lk_user_i`=1, otherwise the kernel field. A read needs a nonzero field and a write needs bit 1 set. A failed check reports a protection fault with no side effects.
- R6: A refill of a page and tag already present rewrites that slot. Otherwise the refill fills the lowest-numbered empty slot. A refill clears the slot's reference and modify bits.
- R7: With all slots full, a refill replaces the pseudo-LRU victim. The tree has 7 node bits for 8 slots: node n has children 2n+1 and 2n+2, and a 0 bit sends the victim search left. Each hit and each refill sets every node on the slot's path so that it points away from that slot.
- R8: A hit reports the entry's reference and modify bits as they were before the access. It then sets the reference bit, and a write hit also sets the modify bit.
- R9: In tagged mode a context switch loads `ctx_tag_i` as the current tag and keeps every entry. Switching back to an earlier tag makes its entries hit again.
- R10: In untagged mode a context switch empties every slot, and a refill in the same cycle is discarded.
- R11: An invalidate empties the entry matching its page, and also its tag in tagged mode. All other entries stay.
- R12: A lookup is judged on the state before its clock edge. Within one edge, the invalidate is applied before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tag_en_i | input | 1 | 1: tags take part in matching and context switches keep entries |
| ctx_sw_i | input | 1 | Context switch strobe |
| ctx_tag_i | input | 8 | New current process tag |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | 20 | Virtual page to translate |
| lk_write_i | input | 1 | Lookup is a write |
| lk_user_i | input | 1 | Lookup is from user mode |
| res_valid_o | output | 1 | Result present this cycle |
| res_code_o | output | 2 | 0 hit, 1 miss, 2 page fault, 3 protection fault |
| res_ppn_o | output | 20 | Physical page on a hit |
| res_cacheable_o | output | 1 | Cacheable flag on a hit |
| res_ref_o | output | 1 | Reference bit before the access |
| res_mod_o | output | 1 | Modify bit before the access |
| rf_we_i | input | 1 | Refill strobe |
| rf_vpn_i | input | 20 | Refill virtual page |
| rf_tag_i | input | 8 | Refill process tag |
| rf_ppn_i | input | 20 | Refill physical page |
| rf_pte_valid_i | input | 1 | Refill page-valid flag |
| rf_krights_i | input | 2 | Refill kernel rights |
| rf_urights_i | input | 2 | Refill user rights |
| rf_cacheable_i | input | 1 | Refill cacheable flag |
| inv_i | input | 1 | Invalidate-one strobe |
| inv_vpn_i | input | 20 | Page to invalidate |
| inv_tag_i | input | 8 | Tag to invalidate |

## Verification
Two pairs of operations can land on the same edge, and the bench drives each pair in one cycle. In the first, a lookup hits a page while an invalidate for that same page arrives. The lookup must still report a hit with the page's frame, and the next lookup must miss. In the second, an untagged context switch and a refill of a fresh page arrive together. The refill must leave no trace, so a following lookup of that page misses. In both cases the bench's own model of the entries and the replacement tree gives the expected values.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    RES_HIT     = 2'd0,
    RES_MISS    = 2'd1,
    RES_PGFAULT = 2'd2,
    RES_PROT    = 2'd3
  } res_code_e;

  // Rights field: 0 none, 1 read-only, 2/3 read-write.
  function automatic logic access_ok(input logic [1:0] rights, input logic wr);
    return wr ? rights[1] : (rights != 2'd0);
  endfunction

  function automatic res_code_e classify(input logic found, input logic pte_ok,
                                         input logic rights_ok);
    if (!found)          return RES_MISS;
    else if (!pte_ok)    return RES_PGFAULT;
    else if (!rights_ok) return RES_PROT;
    else                 return RES_HIT;
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N  = 8,
  parameter int VW = 20,
  parameter int TW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         used_i,
  input  logic [N-1:0][VW-1:0] vpn_i,
  input  logic [N-1:0][TW-1:0] tag_i,
  input  logic [VW-1:0]        key_vpn_i,
  input  logic [TW-1:0]        key_tag_i,
  input  logic                 tag_en_i,
  output logic [N-1:0]         match_o,
  output logic                 any_o,
  output logic [IW-1:0]        idx_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = used_i[g] && (vpn_i[g] == key_vpn_i) &&
                        (!tag_en_i || (tag_i[g] == key_tag_i));
  end

  assign any_o = |match_o;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_o[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int WAYS = 8,
  localparam int LVL = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch_a_en_i,
  input  logic [LVL-1:0]  touch_a_way_i,
  input  logic            touch_b_en_i,
  input  logic [LVL-1:0]  touch_b_way_i,
  output logic [LVL-1:0]  victim_o,
  output logic [WAYS-2:0] tree_o
);

  logic [WAYS-2:0] tree_q, tree_d;

  // Point every node on the path away from the touched way.
  function automatic logic [WAYS-2:0] f_touch(input logic [WAYS-2:0] t,
                                              input logic [LVL-1:0] w);
    logic [WAYS-2:0] r;
    int n;
    r = t;
    n = 0;
    for (int l = 0; l < LVL; l++) begin
      r[n] = ~w[LVL-1-l];
      n = 2 * n + 1 + int'(w[LVL-1-l]);
    end
    return r;
  endfunction

  // Follow the node bits: 0 left, 1 right.
  function automatic logic [LVL-1:0] f_victim(input logic [WAYS-2:0] t);
    logic [LVL-1:0] v;
    int n;
    v = '0;
    n = 0;
    for (int l = 0; l < LVL; l++) begin
      v[LVL-1-l] = t[n];
      n = 2 * n + 1 + int'(t[n]);
    end
    return v;
  endfunction

  always_comb begin
    tree_d = tree_q;
    if (touch_a_en_i) tree_d = f_touch(tree_d, touch_a_way_i);
    if (touch_b_en_i) tree_d = f_touch(tree_d, touch_b_way_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end

  assign victim_o = f_victim(tree_q);
  assign tree_o   = tree_q;

  // R7: the way just touched is never the next victim
  p_touched_not_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_b_en_i |=> (victim_o != $past(touch_b_way_i)));

endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int TAG_W   = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_en_i,
  input  logic             ctx_sw_i,
  input  logic [TAG_W-1:0] ctx_tag_i,
  input  logic             lk_req_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             lk_write_i,
  input  logic             lk_user_i,
  output logic             res_valid_o,
  output logic [1:0]       res_code_o,
  output logic [PPN_W-1:0] res_ppn_o,
  output logic             res_cacheable_o,
  output logic             res_ref_o,
  output logic             res_mod_o,
  input  logic             rf_we_i,
  input  logic [VPN_W-1:0] rf_vpn_i,
  input  logic [TAG_W-1:0] rf_tag_i,
  input  logic [PPN_W-1:0] rf_ppn_i,
  input  logic             rf_pte_valid_i,
  input  logic [1:0]       rf_krights_i,
  input  logic [1:0]       rf_urights_i,
  input  logic             rf_cacheable_i,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic [TAG_W-1:0] inv_tag_i
);
  import tlb_pkg::*;

  // entry storage
  logic [ENTRIES-1:0]             used_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0]             pv_q, c_q, ref_q, mod_q;
  logic [ENTRIES-1:0][1:0]        kr_q, ur_q;
  logic [TAG_W-1:0]               cur_tag_q;
  logic [IW-1:0]                  res_idx_q;

  // named events
  logic               flush_ev, rf_do, lk_hit_ev;
  logic [ENTRIES-1:0] lk_match, rf_match, inv_match;
  logic               lk_any, rf_any, inv_any;
  logic [IW-1:0]      lk_idx, rf_idx, rf_slot, victim, free_idx;
  logic               free_any;
  logic [1:0]         lk_rights;
  res_code_e          lk_code;
  logic [ENTRIES-2:0] plru_tree;

  tlb_cam #(.N(ENTRIES), .VW(VPN_W), .TW(TAG_W)) i_cam_lk (
    .used_i(used_q), .vpn_i(vpn_q), .tag_i(tag_q),
    .key_vpn_i(lk_vpn_i), .key_tag_i(cur_tag_q), .tag_en_i(tag_en_i),
    .match_o(lk_match), .any_o(lk_any), .idx_o(lk_idx));

  tlb_cam #(.N(ENTRIES), .VW(VPN_W), .TW(TAG_W)) i_cam_rf (
    .used_i(used_q), .vpn_i(vpn_q), .tag_i(tag_q),
    .key_vpn_i(rf_vpn_i), .key_tag_i(rf_tag_i), .tag_en_i(tag_en_i),
    .match_o(rf_match), .any_o(rf_any), .idx_o(rf_idx));

  tlb_cam #(.N(ENTRIES), .VW(VPN_W), .TW(TAG_W)) i_cam_inv (
    .used_i(used_q), .vpn_i(vpn_q), .tag_i(tag_q),
    .key_vpn_i(inv_vpn_i), .key_tag_i(inv_tag_i), .tag_en_i(tag_en_i),
    .match_o(inv_match), .any_o(inv_any), .idx_o());

  tlb_plru #(.WAYS(ENTRIES)) i_plru (
    .clk(clk), .rst_n(rst_n),
    .touch_a_en_i(lk_hit_ev), .touch_a_way_i(lk_idx),
    .touch_b_en_i(rf_do),     .touch_b_way_i(rf_slot),
    .victim_o(victim), .tree_o(plru_tree));

  // lookup classification
  assign lk_rights = lk_user_i ? ur_q[lk_idx] : kr_q[lk_idx];
  assign lk_code   = classify(lk_any, pv_q[lk_idx], access_ok(lk_rights, lk_write_i));
  assign lk_hit_ev = lk_req_i && (lk_code == RES_HIT);

  // refill slot choice: existing mapping, then lowest free, then victim
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign rf_slot  = rf_any ? rf_idx : (free_any ? free_idx : victim);
  assign flush_ev = ctx_sw_i && !tag_en_i;
  assign rf_do    = rf_we_i && !flush_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q    <= '0;
      vpn_q     <= '0;
      tag_q     <= '0;
      ppn_q     <= '0;
      pv_q      <= '0;
      c_q       <= '0;
      ref_q     <= '0;
      mod_q     <= '0;
      kr_q      <= '0;
      ur_q      <= '0;
      cur_tag_q <= '0;
    end else begin
      if (ctx_sw_i) cur_tag_q <= ctx_tag_i;
      if (lk_hit_ev) begin
        ref_q[lk_idx] <= 1'b1;
        if (lk_write_i) mod_q[lk_idx] <= 1'b1;
      end
      if (flush_ev) begin
        used_q <= '0;
      end else begin
        if (inv_i) used_q <= used_q & ~inv_match;
        if (rf_do) begin
          used_q[rf_slot] <= 1'b1;
          vpn_q[rf_slot]  <= rf_vpn_i;
          tag_q[rf_slot]  <= rf_tag_i;
          ppn_q[rf_slot]  <= rf_ppn_i;
          pv_q[rf_slot]   <= rf_pte_valid_i;
          kr_q[rf_slot]   <= rf_krights_i;
          ur_q[rf_slot]   <= rf_urights_i;
          c_q[rf_slot]    <= rf_cacheable_i;
          ref_q[rf_slot]  <= 1'b0;
          mod_q[rf_slot]  <= 1'b0;
        end
      end
    end
  end

  // registered result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o     <= 1'b0;
      res_code_o      <= RES_MISS;
      res_ppn_o       <= '0;
      res_cacheable_o <= 1'b0;
      res_ref_o       <= 1'b0;
      res_mod_o       <= 1'b0;
      res_idx_q       <= '0;
    end else begin
      res_valid_o     <= lk_req_i;
      res_code_o      <= lk_code;
      res_ppn_o       <= lk_hit_ev ? ppn_q[lk_idx] : '0;
      res_cacheable_o <= lk_hit_ev && c_q[lk_idx];
      res_ref_o       <= lk_hit_ev && ref_q[lk_idx];
      res_mod_o       <= lk_hit_ev && mod_q[lk_idx];
      res_idx_q       <= lk_idx;
    end
  end

  // R2: every request yields a result one cycle later
  p_result_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req_i |=> res_valid_o);

  // R4 / R5: faults and misses leave the replacement state alone
  p_fault_no_touch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req_i && (lk_code != RES_HIT) && !rf_we_i) |=> $stable(plru_tree));

  // R6: a fresh refill with room grows occupancy by one
  p_refill_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_i && !flush_ev && !inv_i && !rf_any && (used_q != '1)) |=>
    ($countones(used_q) == $countones($past(used_q)) + 1));

  // R8: a reported hit leaves its entry referenced
  p_ref_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && (res_code_o == RES_HIT) && !$past(rf_we_i)) |-> ref_q[res_idx_q]);

  // R9: a tagged switch keeps occupancy
  p_tagged_switch_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_sw_i && tag_en_i && !inv_i && !rf_we_i) |=> (used_q == $past(used_q)));

  // R10: an untagged switch empties everything
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_sw_i && !tag_en_i) |=> (used_q == '0));

  // R11: invalidating a present mapping removes at least one entry
  p_inv_removes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_i && inv_any && !rf_we_i && !ctx_sw_i) |=>
    ($countones(used_q) < $countones($past(used_q))));

endmodule

// File: tb/test_tagged_tlb.sv
module test_tagged_tlb;
  localparam int N  = 8;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic tag_en_i, ctx_sw_i, lk_req_i, lk_write_i, lk_user_i;
  logic [TW-1:0] ctx_tag_i, rf_tag_i, inv_tag_i;
  logic [VW-1:0] lk_vpn_i, rf_vpn_i, inv_vpn_i;
  logic res_valid_o, res_cacheable_o, res_ref_o, res_mod_o;
  logic [1:0] res_code_o;
  logic [PW-1:0] res_ppn_o, rf_ppn_i;
  logic rf_we_i, rf_pte_valid_i, rf_cacheable_i, inv_i;
  logic [1:0] rf_krights_i, rf_urights_i;

  always #5 clk = ~clk;

  tagged_tlb i_tagged_tlb (
    .clk(clk), .rst_n(rst_n), .tag_en_i(tag_en_i), .ctx_sw_i(ctx_sw_i),
    .ctx_tag_i(ctx_tag_i), .lk_req_i(lk_req_i), .lk_vpn_i(lk_vpn_i),
    .lk_write_i(lk_write_i), .lk_user_i(lk_user_i), .res_valid_o(res_valid_o),
    .res_code_o(res_code_o), .res_ppn_o(res_ppn_o), .res_cacheable_o(res_cacheable_o),
    .res_ref_o(res_ref_o), .res_mod_o(res_mod_o), .rf_we_i(rf_we_i),
    .rf_vpn_i(rf_vpn_i), .rf_tag_i(rf_tag_i), .rf_ppn_i(rf_ppn_i),
    .rf_pte_valid_i(rf_pte_valid_i), .rf_krights_i(rf_krights_i),
    .rf_urights_i(rf_urights_i), .rf_cacheable_i(rf_cacheable_i),
    .inv_i(inv_i), .inv_vpn_i(inv_vpn_i), .inv_tag_i(inv_tag_i));

  int n_tests = 0;
  int n_fail  = 0;

  // bench model
  bit            m_used[N];
  logic [VW-1:0] m_vpn[N];
  logic [TW-1:0] m_tag[N];
  logic [PW-1:0] m_ppn[N];
  bit            m_pv[N], m_c[N], m_ref[N], m_mod[N];
  logic [1:0]    m_kr[N], m_ur[N];
  bit            m_tree[N-1];
  logic [TW-1:0] m_cur;
  bit            m_ten;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(input logic [VW-1:0] v, input logic [TW-1:0] t);
    for (int i = 0; i < N; i++)
      if (m_used[i] && m_vpn[i] == v && (!m_ten || m_tag[i] == t)) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int n = 0;
    int w = 0;
    for (int l = 0; l < 3; l++) begin
      int b = int'(m_tree[n]);
      w = 2 * w + b;
      n = 2 * n + 1 + b;
    end
    return w;
  endfunction

  function automatic void m_touch(input int w);
    int n = 0;
    for (int l = 0; l < 3; l++) begin
      int d = (w >> (2 - l)) & 1;
      m_tree[n] = (d == 0);
      n = 2 * n + 1 + d;
    end
  endfunction

  function automatic void m_apply_lookup(input int idx, input bit wr, input int code);
    if (code == 0) begin
      m_touch(idx);
      m_ref[idx] = 1'b1;
      if (wr) m_mod[idx] = 1'b1;
    end
  endfunction

  function automatic void m_apply_inv(input logic [VW-1:0] v, input logic [TW-1:0] t);
    for (int i = 0; i < N; i++)
      if (m_used[i] && m_vpn[i] == v && (!m_ten || m_tag[i] == t)) m_used[i] = 1'b0;
  endfunction

  function automatic int m_code(input int idx, input bit wr, input bit usr);
    logic [1:0] r;
    if (idx < 0) return 1;
    if (!m_pv[idx]) return 2;
    r = usr ? m_ur[idx] : m_kr[idx];
    if (wr ? !r[1] : (r == 2'd0)) return 3;
    return 0;
  endfunction

  task automatic idle_inputs();
    ctx_sw_i = 0; ctx_tag_i = '0; lk_req_i = 0; lk_vpn_i = '0; lk_write_i = 0;
    lk_user_i = 0; rf_we_i = 0; rf_vpn_i = '0; rf_tag_i = '0; rf_ppn_i = '0;
    rf_pte_valid_i = 0; rf_krights_i = '0; rf_urights_i = '0; rf_cacheable_i = 0;
    inv_i = 0; inv_vpn_i = '0; inv_tag_i = '0;
  endtask

  task automatic check_result(input string req, input int idx, input int code);
    chk(req, "valid", 32'(res_valid_o), 32'd1);
    chk(req, "code", 32'(res_code_o), 32'(code));
    chk(req, "ppn", 32'(res_ppn_o), (code == 0) ? 32'(m_ppn[idx]) : 32'd0);
    chk(req, "cacheable", 32'(res_cacheable_o), (code == 0) ? 32'(m_c[idx]) : 32'd0);
    chk(req, "ref", 32'(res_ref_o), (code == 0) ? 32'(m_ref[idx]) : 32'd0);
    chk(req, "mod", 32'(res_mod_o), (code == 0) ? 32'(m_mod[idx]) : 32'd0);
  endtask

  // starts and ends at a falling edge
  task automatic lookup(input logic [VW-1:0] v, input bit wr, input bit usr,
                        input string req);
    int idx, code;
    idx  = m_find(v, m_cur);
    code = m_code(idx, wr, usr);
    lk_req_i = 1; lk_vpn_i = v; lk_write_i = wr; lk_user_i = usr;
    @(negedge clk);
    lk_req_i = 0;
    check_result(req, idx, code);
    m_apply_lookup(idx, wr, code);
  endtask

  task automatic drive_refill(input logic [VW-1:0] v, input logic [TW-1:0] t,
                              input logic [PW-1:0] p, input bit pv,
                              input logic [1:0] kr, input logic [1:0] ur, input bit c);
    rf_we_i = 1; rf_vpn_i = v; rf_tag_i = t; rf_ppn_i = p; rf_pte_valid_i = pv;
    rf_krights_i = kr; rf_urights_i = ur; rf_cacheable_i = c;
  endtask

  function automatic void m_apply_refill(input logic [VW-1:0] v, input logic [TW-1:0] t,
                                         input logic [PW-1:0] p, input bit pv,
                                         input logic [1:0] kr, input logic [1:0] ur,
                                         input bit c);
    int s = m_find(v, t);
    if (s < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_used[i]) s = i;
    if (s < 0) s = m_victim();
    m_used[s] = 1; m_vpn[s] = v; m_tag[s] = t; m_ppn[s] = p; m_pv[s] = pv;
    m_kr[s] = kr; m_ur[s] = ur; m_c[s] = c; m_ref[s] = 0; m_mod[s] = 0;
    m_touch(s);
  endfunction

  task automatic refill(input logic [VW-1:0] v, input logic [TW-1:0] t,
                        input logic [PW-1:0] p, input bit pv,
                        input logic [1:0] kr, input logic [1:0] ur, input bit c);
    drive_refill(v, t, p, pv, kr, ur, c);
    @(negedge clk);
    rf_we_i = 0;
    m_apply_refill(v, t, p, pv, kr, ur, c);
  endtask

  task automatic inval(input logic [VW-1:0] v, input logic [TW-1:0] t);
    inv_i = 1; inv_vpn_i = v; inv_tag_i = t;
    @(negedge clk);
    inv_i = 0;
    m_apply_inv(v, t);
  endtask

  task automatic ctx_switch(input logic [TW-1:0] t, input bit ten);
    tag_en_i = ten; m_ten = ten;
    ctx_sw_i = 1; ctx_tag_i = t;
    @(negedge clk);
    ctx_sw_i = 0;
    m_cur = t;
    if (!ten) for (int i = 0; i < N; i++) m_used[i] = 0;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) lookup(VW'(20'h100 + i), 1'b0, 1'b0, req);
    for (int j = 0; j < 4; j++) lookup(VW'(20'h200 + j), 1'b0, 1'b0, req);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int idx;
    for (int i = 0; i < N; i++) begin
      m_used[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
    end
    for (int i = 0; i < N - 1; i++) m_tree[i] = 0;
    m_cur = '0; m_ten = 1;
    tag_en_i = 1;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "res_valid after reset", 32'(res_valid_o), 32'd0);
    lookup(20'h00100, 1'b0, 1'b0, "R1");
    lookup(20'h00005, 1'b1, 1'b1, "R1");

    // R6: fill all slots in order; R2/R4/R5/R8 over every right and mode
    ctx_switch(8'd3, 1'b1);
    for (int i = 0; i < N; i++)
      refill(VW'(20'h100 + i), 8'd3, PW'(20'h5000 + 7 * i), (i != 6), 2'd3,
             2'(i % 4), i[0]);
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 4; k++)
        lookup(VW'(20'h100 + i), k[0], k[1], "R2 R4 R5 R8");

    // R7: replacement once full
    for (int j = 0; j < 4; j++)
      refill(VW'(20'h200 + j), 8'd3, PW'(20'h9000 + j), 1'b1, 2'd3, 2'd3, 1'b1);
    sweep("R7");

    // R6: rewriting an existing mapping in place
    refill(20'h00200, 8'd3, 20'h0abcd, 1'b1, 2'd3, 2'd1, 1'b0);
    lookup(20'h00200, 1'b0, 1'b1, "R6");
    lookup(20'h00200, 1'b1, 1'b1, "R6");

    // R3 / R9: tagged switch
    ctx_switch(8'd4, 1'b1);
    sweep("R3");
    ctx_switch(8'd3, 1'b1);
    sweep("R9");

    // R11: invalidate one page; also an invalidate with the wrong tag
    inval(20'h00201, 8'd3);
    inval(20'h00202, 8'd9);
    sweep("R11");

    // R12: lookup hit and invalidate of the same page in one cycle
    idx = m_find(20'h00203, m_cur);
    lk_req_i = 1; lk_vpn_i = 20'h00203; lk_write_i = 1; lk_user_i = 0;
    inv_i = 1; inv_vpn_i = 20'h00203; inv_tag_i = 8'd3;
    @(negedge clk);
    lk_req_i = 0; inv_i = 0;
    check_result("R12", idx, m_code(idx, 1'b1, 1'b0));
    m_apply_lookup(idx, 1'b1, m_code(idx, 1'b1, 1'b0));
    m_apply_inv(20'h00203, 8'd3);
    lookup(20'h00203, 1'b0, 1'b0, "R12");

    // R10: untagged switch empties all; refill in the same cycle dropped
    drive_refill(20'h00300, 8'd0, 20'h01234, 1'b1, 2'd3, 2'd3, 1'b1);
    ctx_switch(8'd0, 1'b0);
    rf_we_i = 0;
    sweep("R10");
    lookup(20'h00300, 1'b0, 1'b0, "R10");

    // R10 / R3: untagged matching ignores tags
    refill(20'h00300, 8'd7, 20'h04321, 1'b1, 2'd3, 2'd3, 1'b0);
    lookup(20'h00300, 1'b1, 1'b1, "R3");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule